// File: doc/BRIEF.md
# Flash Write-Buffer Program Sequencer

This block programs a run of consecutive 16-bit words into a parallel NOR flash with one buffered program operation. It does not use a separate program command for each word. A host pulses a start strobe with a start word address and a word count. The block then drives a fixed series of single-word bus write requests: the two-cycle unlock prefix, the buffer-load command, the count minus one, each data word, and a confirm command. It does not time the bus cycles itself. Each write is handed to a shared bus-cycle timing engine through a request/acknowledge pair. That engine is the one the command sequencer also uses.

Data words arrive on a ready/valid stream. The block takes one word into a holding register only while it is in the data-load phase. It writes that word at the next address in turn, then asks for the next word. When the confirm write is acknowledged, the block pulses a start strobe to the completion poller, together with the program-class timeout budget. A count of zero or above the buffer limit is refused with an error pulse, and no bus cycle is issued.

Top module: `flash_wbuf_prog`

## Requirements
- R1: After an accepted start, the first bus write is data 0x00AA at word address 0x555, and the second is data 0x0055 at word address 0x2AA.
- R2: The third bus write is data 0x0025 at the start address. The fourth is the word count minus one, zero-extended, at the start address.
- R3: The next COUNT bus writes carry the stream words in arrival order, at addresses start, start+1, …, start+COUNT-1, taken modulo 2^ADDR_W.
- R4: The last bus write of an operation is data 0x0029 at the address of the last loaded word (start+COUNT-1).
- R5: In the cycle after the confirm write is acknowledged, poll_start_o is high for exactly one cycle, poll_tmo_o equals the program timeout parameter, and busy_o is low.
- R6: A start with count 0 or count above MAX_WORDS (32) sets err_o for exactly the next cycle. The block issues no bus write and does not become busy.
- R7: wready_o is high only in the data-load phase while no word is held, and never together with bus_req_o. While wvalid_i is low, no data write is issued and the address does not advance.
- R8: Once raised, bus_req_o stays high with stable bus_addr_o and bus_wdata_o until bus_ack_i is seen. Each acknowledge completes exactly one write.
- R9: start_i is ignored while busy_o is high. The sequence in progress is unchanged, and no error is raised.
- R10: During and right after reset, busy_o, err_o, wready_o, bus_req_o and poll_start_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled while idle |
| start_addr_i | input | ADDR_W | First word address to program |
| count_i | input | CNT_W | Number of words, valid range 1..MAX_WORDS |
| wdata_i | input | DATA_W | Stream data word |
| wvalid_i | input | 1 | Stream word valid |
| wready_o | output | 1 | Block accepts a stream word this cycle |
| bus_req_o | output | 1 | Write request to the shared bus timing engine |
| bus_addr_o | output | ADDR_W | Word address of the requested write |
| bus_wdata_o | output | DATA_W | Data of the requested write |
| bus_ack_i | input | 1 | Timing engine has completed the requested write |
| busy_o | output | 1 | An operation is in progress |
| err_o | output | 1 | One-cycle pulse: start refused for a bad count |
| poll_start_o | output | 1 | One-cycle pulse that hands control to the completion poller |
| poll_tmo_o | output | TMO_W | Timeout budget given to the poller |

## Verification
The error pulse is due one clock after the edge that samples start_i. The bench drives start a few nanoseconds after a rising edge and reads err_o and busy_o the same distance after the next one. A bus write request is visible in the clock after the acknowledge of the previous write. The responder model acknowledges after a delay that varies from 0 to 2 cycles, and it logs each address and data word at the falling edge where it raises the acknowledge. The poller strobe is due one clock after the confirm acknowledge. The bench waits for it edge by edge and then checks that it has gone low one clock later. Every log is compared with an address and data list computed from the start address, the count and a word formula. The sweep covers counts 0 to 40 and 63 at three start addresses, one of which wraps past the top of the address space.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_UNLK_A,
    PH_UNLK_B,
    PH_LOAD_CMD,
    PH_COUNT,
    PH_DATA,
    PH_CONFIRM
  } phase_e;

  localparam logic [11:0] UNLK_ADDR_A  = 12'h555;
  localparam logic [11:0] UNLK_ADDR_B  = 12'h2AA;
  localparam logic [7:0]  UNLK_CODE_A  = 8'hAA;
  localparam logic [7:0]  UNLK_CODE_B  = 8'h55;
  localparam logic [7:0]  LOAD_CODE    = 8'h25;
  localparam logic [7:0]  CONFIRM_CODE = 8'h29;
endpackage

// File: rtl/wbp_ctrl.sv
module wbp_ctrl
  import wbp_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   count_ok_i,
  input  logic   held_i,
  input  logic   last_i,
  input  logic   bus_ack_i,
  output phase_e phase_o,
  output logic   req_o,
  output logic   accept_o,
  output logic   data_ack_o,
  output logic   err_o,
  output logic   poll_start_o
);
  phase_e phase_q, phase_d;
  logic   err_q, poll_q;
  logic   cmd_phase, reject, step;

  assign cmd_phase  = (phase_q == PH_UNLK_A) || (phase_q == PH_UNLK_B) ||
                      (phase_q == PH_LOAD_CMD) || (phase_q == PH_COUNT) ||
                      (phase_q == PH_CONFIRM);
  assign req_o      = cmd_phase || ((phase_q == PH_DATA) && held_i);
  assign step       = req_o && bus_ack_i;
  assign accept_o   = (phase_q == PH_IDLE) && start_i && count_ok_i;
  assign reject     = (phase_q == PH_IDLE) && start_i && !count_ok_i;
  assign data_ack_o = (phase_q == PH_DATA) && step;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:     if (accept_o) phase_d = PH_UNLK_A;
      PH_UNLK_A:   if (step) phase_d = PH_UNLK_B;
      PH_UNLK_B:   if (step) phase_d = PH_LOAD_CMD;
      PH_LOAD_CMD: if (step) phase_d = PH_COUNT;
      PH_COUNT:    if (step) phase_d = PH_DATA;
      PH_DATA:     if (step && last_i) phase_d = PH_CONFIRM;
      PH_CONFIRM:  if (step) phase_d = PH_IDLE;
      default:     phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      err_q   <= 1'b0;
      poll_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      err_q   <= reject;
      poll_q  <= (phase_q == PH_CONFIRM) && step;
    end
  end

  assign phase_o      = phase_q;
  assign err_o        = err_q;
  assign poll_start_o = poll_q;

  // R6
  bad_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && start_i && !count_ok_i) |=> (err_o && phase_q == PH_IDLE && !req_o));
  // R5
  poll_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_start_o |=> !poll_start_o);
  // R9
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE && phase_q != PH_CONFIRM) |=> (phase_q != PH_IDLE && !err_o));
endmodule

// File: rtl/wbp_addr_gen.sv
module wbp_addr_gen #(
  parameter int ADDR_W    = 24,
  parameter int MAX_WORDS = 32,
  parameter int CNT_W     = $clog2(MAX_WORDS) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              accept_i,
  input  logic              data_ack_i,
  output logic              count_ok_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [ADDR_W-1:0] last_addr_o,
  output logic [CNT_W-1:0]  cnt_m1_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] base_q, cur_q, last_q;
  logic [CNT_W-1:0]  rem_q, cnt_m1_q;

  assign count_ok_o = (count_i != '0) && (count_i <= CNT_W'(MAX_WORDS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      cur_q    <= '0;
      last_q   <= '0;
      rem_q    <= '0;
      cnt_m1_q <= '0;
    end else if (accept_i) begin
      base_q   <= start_addr_i;
      cur_q    <= start_addr_i;
      last_q   <= start_addr_i;
      rem_q    <= count_i;
      cnt_m1_q <= count_i - CNT_W'(1);
    end else if (data_ack_i) begin
      last_q <= cur_q;
      cur_q  <= cur_q + ADDR_W'(1);
      rem_q  <= rem_q - CNT_W'(1);
    end
  end

  assign cur_addr_o  = cur_q;
  assign last_addr_o = last_q;
  assign cnt_m1_o    = cnt_m1_q;
  assign last_o      = (rem_q == CNT_W'(1));

  // R3
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_ack_i && !accept_i) |=> (cur_q == $past(cur_q) + ADDR_W'(1)));
  // R4
  last_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rem_q == '0) |-> (last_q == base_q + ADDR_W'(cnt_m1_q)));
endmodule

// File: rtl/wbp_word_hold.sv
module wbp_word_hold #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_phase_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wvalid_i,
  input  logic              consume_i,
  output logic              wready_o,
  output logic              held_o,
  output logic [DATA_W-1:0] word_o
);
  logic              held_q;
  logic [DATA_W-1:0] word_q;

  assign wready_o = load_phase_i && !held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      word_q <= '0;
    end else if (wvalid_i && wready_o) begin
      held_q <= 1'b1;
      word_q <= wdata_i;
    end else if (consume_i) begin
      held_q <= 1'b0;
    end
  end

  assign held_o = held_q;
  assign word_o = word_q;

  // R7
  hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q && !consume_i) |=> (held_q && $stable(word_q)));
endmodule

// File: rtl/wbp_bus_mux.sv
module wbp_bus_mux
  import wbp_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 6
) (
  input  phase_e            phase_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W-1:0] last_addr_i,
  input  logic [CNT_W-1:0]  cnt_m1_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    addr_o = '0;
    data_o = '0;
    unique case (phase_i)
      PH_UNLK_A:   begin addr_o = ADDR_W'(UNLK_ADDR_A); data_o = DATA_W'(UNLK_CODE_A);  end
      PH_UNLK_B:   begin addr_o = ADDR_W'(UNLK_ADDR_B); data_o = DATA_W'(UNLK_CODE_B);  end
      PH_LOAD_CMD: begin addr_o = start_addr_i;         data_o = DATA_W'(LOAD_CODE);    end
      PH_COUNT:    begin addr_o = start_addr_i;         data_o = DATA_W'(cnt_m1_i);     end
      PH_DATA:     begin addr_o = start_addr_i;         data_o = word_i;                end
      PH_CONFIRM:  begin addr_o = last_addr_i;          data_o = DATA_W'(CONFIRM_CODE); end
      default:     begin addr_o = '0;                   data_o = '0;                    end
    endcase
  end
endmodule

// File: rtl/flash_wbuf_prog.sv
module flash_wbuf_prog
  import wbp_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter int          DATA_W    = 16,
  parameter int          MAX_WORDS = 32,
  parameter int          CNT_W     = $clog2(MAX_WORDS) + 1,
  parameter int          TMO_W     = 32,
  parameter logic [31:0] PROG_TMO  = 32'h0000_1400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  output logic              busy_o,
  output logic              err_o,
  output logic              poll_start_o,
  output logic [TMO_W-1:0]  poll_tmo_o
);
  phase_e            phase;
  logic              count_ok, held, last_word, accept, data_ack;
  logic [ADDR_W-1:0] cur_addr, last_addr;
  logic [CNT_W-1:0]  cnt_m1;
  logic [DATA_W-1:0] word;
  logic [ADDR_W-1:0] mux_addr;

  wbp_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .count_ok_i   (count_ok),
    .held_i       (held),
    .last_i       (last_word),
    .bus_ack_i    (bus_ack_i),
    .phase_o      (phase),
    .req_o        (bus_req_o),
    .accept_o     (accept),
    .data_ack_o   (data_ack),
    .err_o        (err_o),
    .poll_start_o (poll_start_o)
  );

  wbp_addr_gen #(.ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)) u_addr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_addr_i (start_addr_i),
    .count_i      (count_i),
    .accept_i     (accept),
    .data_ack_i   (data_ack),
    .count_ok_o   (count_ok),
    .cur_addr_o   (cur_addr),
    .last_addr_o  (last_addr),
    .cnt_m1_o     (cnt_m1),
    .last_o       (last_word)
  );

  wbp_word_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_phase_i (phase == PH_DATA),
    .wdata_i      (wdata_i),
    .wvalid_i     (wvalid_i),
    .consume_i    (data_ack),
    .wready_o     (wready_o),
    .held_o       (held),
    .word_o       (word)
  );

  // load and count cycles target the first word, which cur_addr holds until data starts
  wbp_bus_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_mux (
    .phase_i      (phase),
    .start_addr_i (cur_addr),
    .last_addr_i  (last_addr),
    .cnt_m1_i     (cnt_m1),
    .word_i       (word),
    .addr_o       (mux_addr),
    .data_o       (bus_wdata_o)
  );

  assign bus_addr_o = mux_addr;
  assign busy_o     = (phase != PH_IDLE);
  assign poll_tmo_o = TMO_W'(PROG_TMO);

  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_wdata_o)));
  // R7
  ready_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wready_o |-> (!bus_req_o && busy_o));
  // R5
  poll_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_start_o |-> (!busy_o && $past(bus_ack_i)));
  // R6
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && !bus_req_o));
endmodule

// File: tb/flash_wbuf_prog_test.sv
module flash_wbuf_prog_test;
  localparam int          ADDR_W    = 24;
  localparam int          DATA_W    = 16;
  localparam int          MAX_WORDS = 32;
  localparam int          CNT_W     = $clog2(MAX_WORDS) + 1;
  localparam int          TMO_W     = 32;
  localparam logic [31:0] PROG_TMO  = 32'h0000_1400;
  localparam int          LOG_N     = 80;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] start_addr_i = '0;
  logic [CNT_W-1:0]  count_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic              wvalid_i = 1'b0;
  logic              wready_o, bus_req_o, bus_ack_i, busy_o, err_o, poll_start_o;
  logic [ADDR_W-1:0] bus_addr_o;
  logic [DATA_W-1:0] bus_wdata_o;
  logic [TMO_W-1:0]  poll_tmo_o;

  always #5 clk = ~clk;

  flash_wbuf_prog #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS),
                    .TMO_W(TMO_W), .PROG_TMO(PROG_TMO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .count_i(count_i), .wdata_i(wdata_i), .wvalid_i(wvalid_i), .wready_o(wready_o),
    .bus_req_o(bus_req_o), .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
    .bus_ack_i(bus_ack_i), .busy_o(busy_o), .err_o(err_o),
    .poll_start_o(poll_start_o), .poll_tmo_o(poll_tmo_o)
  );

  int n_chk = 0, n_fail = 0;
  logic [ADDR_W-1:0] log_addr [LOG_N];
  logic [DATA_W-1:0] log_data [LOG_N];
  int log_n = 0, wait_cnt = 0, rdy_bad = 0;
  int src_n = 0, src_idx = 0, op_id = 0, cyc = 0;
  bit fire = 1'b0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] word_of(input int op, input int k);
    return DATA_W'(32'h5A00 + op * 97 + k * 1031);
  endfunction

  task automatic tick();
    @(posedge clk);
    #3;
  endtask

  // bus timing engine model: acknowledge after 0..2 waiting cycles
  initial begin
    bus_ack_i = 1'b0;
    forever begin
      @(negedge clk);
      if (wready_o && !busy_o) rdy_bad++;
      if (wready_o && bus_req_o) rdy_bad++;
      if (bus_ack_i) begin
        bus_ack_i = 1'b0;
        wait_cnt = 0;
      end else if (bus_req_o) begin
        if (wait_cnt >= (log_n % 3)) begin
          if (log_n < LOG_N) begin
            log_addr[log_n] = bus_addr_o;
            log_data[log_n] = bus_wdata_o;
          end
          log_n++;
          bus_ack_i = 1'b1;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  // data stream source with periodic gaps in valid
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (fire) src_idx++;
      if (!(wvalid_i && !fire)) begin
        wvalid_i = (src_idx < src_n) && (cyc % 4 != 1);
        wdata_i  = word_of(op_id, src_idx);
      end
      fire = wvalid_i && wready_o;
    end
  end

  task automatic run_op(input logic [ADDR_W-1:0] sa, input int cnt);
    bit valid_cnt;
    int guard;
    logic [ADDR_W-1:0] ea;
    logic [DATA_W-1:0] ed;
    valid_cnt = (cnt >= 1) && (cnt <= MAX_WORDS);
    op_id++;
    log_n = 0;
    src_idx = 0;
    src_n = valid_cnt ? cnt : 0;
    start_addr_i = sa;
    count_i = CNT_W'(cnt);
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    if (!valid_cnt) begin
      check(err_o == 1'b1, "R6 err pulse", err_o, 1);
      check(busy_o == 1'b0, "R6 stays idle", busy_o, 0);
      tick();
      check(err_o == 1'b0, "R6 err one cycle", err_o, 0);
      repeat (4) tick();
      check(log_n == 0, "R6 no bus writes", log_n, 0);
      return;
    end
    check(err_o == 1'b0, "R6 no err on good count", err_o, 0);
    check(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
    // R9: a start while busy must be ignored
    tick();
    start_addr_i = 24'h123456;
    count_i = CNT_W'(5);
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    check(err_o == 1'b0, "R9 no err while busy", err_o, 0);
    guard = 0;
    while (!poll_start_o && guard < 2000) begin
      tick();
      guard++;
    end
    check(poll_start_o == 1'b1, "R5 poll strobe", poll_start_o, 1);
    check(poll_tmo_o == TMO_W'(PROG_TMO), "R5 poll timeout", poll_tmo_o, PROG_TMO);
    check(busy_o == 1'b0, "R5 idle with poll", busy_o, 0);
    tick();
    check(poll_start_o == 1'b0, "R5 poll one cycle", poll_start_o, 0);
    check(log_n == cnt + 5, "R8 bus write count", log_n, cnt + 5);
    check(src_idx == cnt, "R7 words consumed", src_idx, cnt);
    if (log_n == cnt + 5) begin
      for (int i = 0; i < cnt + 5; i++) begin
        if (i == 0)            begin ea = 24'h000555; ed = 16'h00AA; end
        else if (i == 1)       begin ea = 24'h0002AA; ed = 16'h0055; end
        else if (i == 2)       begin ea = sa; ed = 16'h0025; end
        else if (i == 3)       begin ea = sa; ed = DATA_W'(cnt - 1); end
        else if (i < cnt + 4)  begin ea = sa + ADDR_W'(i - 4); ed = word_of(op_id, i - 4); end
        else                   begin ea = sa + ADDR_W'(cnt - 1); ed = 16'h0029; end
        if (i < 2)            check(log_addr[i] == ea && log_data[i] == ed, "R1 unlock",
                                    {log_addr[i], log_data[i]}, {ea, ed});
        else if (i < 4)       check(log_addr[i] == ea && log_data[i] == ed, "R2 load/count",
                                    {log_addr[i], log_data[i]}, {ea, ed});
        else if (i < cnt + 4) check(log_addr[i] == ea && log_data[i] == ed, "R3 data word",
                                    {log_addr[i], log_data[i]}, {ea, ed});
        else                  check(log_addr[i] == ea && log_data[i] == ed, "R4 confirm",
                                    {log_addr[i], log_data[i]}, {ea, ed});
      end
    end
  endtask

  initial begin
    logic [ADDR_W-1:0] bases [3];
    bases[0] = 24'h000000;
    bases[1] = 24'h4AB3C1;
    bases[2] = 24'hFFFFF0;
    #2;
    check(busy_o == 0 && err_o == 0 && wready_o == 0 && bus_req_o == 0 && poll_start_o == 0,
          "R10 outputs in reset", {busy_o, err_o, wready_o, bus_req_o, poll_start_o}, 0);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check(busy_o == 0 && err_o == 0 && wready_o == 0 && bus_req_o == 0 && poll_start_o == 0,
          "R10 outputs after reset", {busy_o, err_o, wready_o, bus_req_o, poll_start_o}, 0);
    for (int b = 0; b < 3; b++) begin
      for (int c = 0; c <= 40; c++) run_op(bases[b], c);
      run_op(bases[b], 63);
    end
    check(rdy_bad == 0, "R7 ready outside load phase", rdy_bad, 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule